// File: doc/BRIEF.md
# Programmable Skew Clock Phase Generator

This block turns one fast clock, whose period is the skew step, into four pairs of derived clocks. A phase counter counts modulo N ticks to mark one nominal output period. A range select picks N. Each pair has two three-level selects. The pair decodes them into a phase shift, a divide-by-2, a divide-by-4 or an inversion of the nominal clock. Pairs 1 and 2 shift in single-tick steps. Pairs 3 and 4 shift in two-tick steps, and their extreme codes select the divided and inverted functions.

Selects may be changed at any time. A change is held back until the phase counter next returns to zero, so a period is never cut short. A test select switches the block into bypass. In bypass a synchronised copy of an external reference drives the outputs. Each pair's inversion or division still applies, and the division counts falling edges of the reference.

Top module: `skew_clock_gen`

## Requirements
- R1: Each select field is a 2-bit three-level code: 00 is LOW, 01 is MID, 10 is HIGH. The code 11 behaves exactly as MID.
- R2: The range select sets the period N in ticks: LOW gives 44, MID gives 26, HIGH gives 16. With select code MM, an output is high when the phase p satisfies p < N/2, so it has a 50% duty cycle.
- R3: Pairs 1 and 2 (fsel bits [3:0] and [7:4], F1 in the upper two bits of each nibble, F0 in the lower two) take an offset d = 3*F1 + F0 - 4. Here LOW=0, MID=1 and HIGH=2, so the codes LL through HH give -4 through +4. The output is high when ((p - d) mod N) < N/2.
- R4: Pairs 3 and 4 (fsel bits [11:8] and [15:12]) use the same rule with d = 2*(3*F1 + F0 - 4) for every code other than LL and HH. This gives offsets from -6 to +6 in steps of 2.
- R5: Code LL on pair 3 or 4 gives divide-by-2, and code HH on pair 3 gives divide-by-4. Let i be the period index (0 to 3, advanced at each counter wrap, restarted at 0 by a resync) and e = i*N + p. Divide-by-2 is high when ((e mod 2N) + N/2) mod 2N < N. Divide-by-4 is high when (e + 3N/2) mod 4N < 2N. All divided outputs therefore fall together with the nominal clock.
- R6: Code HH on pair 4 gives the complement of the nominal (MM) waveform.
- R7: The two outputs of a pair (clk_a[k], clk_b[k]) are equal in every cycle.
- R8: When test_sel is not LOW, the block is in bypass. A shifting pair outputs the level ref_in had at the rising edge two edges earlier. An inverting pair outputs the complement of that level. A divide-by-2 pair outputs bit 0, and a divide-by-4 pair outputs bit 1, of a 2-bit count of falling edges of that delayed reference. The count starts at 0 after reset.
- R9: The range and function selects are sampled on the first active cycle after reset and then only in the cycle in which the phase counter wraps. At that wrap the period index restarts at 0 if any select differs from the held value, and otherwise advances by one.
- R10: rst_n is an asynchronous active-low reset. While it is low, all outputs are low. The outputs stay low for the first two rising edges after it is released. The third rising edge outputs the waveform value for phase 0 and period index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast time-unit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_in | input | 1 | External reference used in bypass |
| test_sel | input | 2 | Three-level bypass select (LOW = normal) |
| range_sel | input | 2 | Three-level period select |
| fsel | input | 16 | Four nibbles of {F1,F0} function selects, pair 1 in bits [3:0] |
| clk_a | output | 4 | First output of each pair, bit k for pair k+1 |
| clk_b | output | 4 | Second output of each pair, bit k for pair k+1 |

## Verification
The bench predicts every output bit on every cycle, and it changes selects part-way through a period. A block that applied a change at once would show a runt or a wrongly placed edge before the next phase zero. A block that failed to restart the period index would misplace the divided falling edges. Divide-by-4 runs for many unchanged periods, so an index that wraps wrongly or an edge aligned to rising instead of falling is caught. The runs also cover negative offsets that wrap around phase zero and the unused code 11 on the range and function selects. In bypass the reference is toggled at several rates. A wrong sync latency or an edge counter on the wrong polarity then shows up as a one-cycle shift or a swapped divided phase.

// File: rtl/skew_pkg.sv
package skew_pkg;

  localparam logic [1:0] T_LOW  = 2'b00;
  localparam logic [1:0] T_MID  = 2'b01;
  localparam logic [1:0] T_HIGH = 2'b10;

  typedef enum logic [1:0] {
    FN_SHIFT = 2'd0,
    FN_DIV2  = 2'd1,
    FN_DIV4  = 2'd2,
    FN_INV   = 2'd3
  } pair_fn_e;

  typedef struct packed {
    pair_fn_e           fn;
    logic signed [3:0]  off;
  } pair_cfg_t;

  // Unused code 11 folds onto MID, like a floating strap.
  function automatic logic [1:0] tern_norm(input logic [1:0] raw);
    return (raw == 2'b11) ? T_MID : raw;
  endfunction

endpackage

// File: rtl/pair_decode.sv
module pair_decode
  import skew_pkg::*;
#(
  parameter bit WIDE    = 1'b0,
  parameter bit HH_DIV4 = 1'b0
) (
  input  logic [3:0] sel,
  output pair_cfg_t  cfg
);

  logic [1:0] f1_n;
  logic [1:0] f0_n;
  logic [3:0] code9;

  always_comb begin
    f1_n  = tern_norm(sel[3:2]);
    f0_n  = tern_norm(sel[1:0]);
    code9 = ({2'b00, f1_n} * 4'd3) + {2'b00, f0_n};
  end

  generate
    if (WIDE) begin : g_wide
      logic [2:0] step;
      always_comb begin
        step    = code9[2:0] - 3'd4;
        cfg.fn  = FN_SHIFT;
        cfg.off = {step, 1'b0};
        if (code9 == 4'd0) begin
          cfg.fn  = FN_DIV2;
          cfg.off = '0;
        end else if (code9 == 4'd8) begin
          cfg.fn  = HH_DIV4 ? FN_DIV4 : FN_INV;
          cfg.off = '0;
        end
      end
    end else begin : g_narrow
      always_comb begin
        cfg.fn  = FN_SHIFT;
        cfg.off = code9 - 4'd4;
      end
    end
  endgenerate

endmodule

// File: rtl/phase_counter.sv
module phase_counter
  import skew_pkg::*;
#(
  parameter int N_LO = 44,
  parameter int N_MD = 26,
  parameter int N_HI = 16,
  parameter int CW   = 6,
  parameter int SELW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      range_sel,
  input  logic [SELW-1:0] fsel,
  output logic [CW-1:0]   phase,
  output logic [1:0]      idx,
  output logic [CW-1:0]   n_cur,
  output logic [SELW-1:0] sel_cur
);

  logic [CW-1:0]   phase_q, phase_d, n_use;
  logic [1:0]      idx_q, idx_d, rng_q, rng_use;
  logic [SELW-1:0] sel_q, sel_use;
  logic            fresh_q, wrap, load, chg;

  always_comb begin
    rng_use = fresh_q ? range_sel : rng_q;
    sel_use = fresh_q ? fsel : sel_q;
    case (tern_norm(rng_use))
      T_LOW:   n_use = CW'(N_LO);
      T_MID:   n_use = CW'(N_MD);
      default: n_use = CW'(N_HI);
    endcase
    wrap    = (phase_q == n_use - CW'(1));
    load    = wrap | fresh_q;
    chg     = (range_sel != rng_q) | (fsel != sel_q);
    phase_d = wrap ? '0 : phase_q + CW'(1);
    idx_d   = idx_q;
    if (wrap) idx_d = chg ? 2'd0 : idx_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      idx_q   <= '0;
      fresh_q <= 1'b1;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      fresh_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rng_q <= '0;
      sel_q <= '0;
    end else if (load) begin
      rng_q <= range_sel;
      sel_q <= fsel;
    end
  end

  assign phase   = phase_q;
  assign idx     = idx_q;
  assign n_cur   = n_use;
  assign sel_cur = sel_use;

  AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q < n_use);                                                    // R2
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == n_use - CW'(1)) |=> (phase_q == '0));                    // R2
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap && !fresh_q) |=> ($stable(sel_q) && $stable(rng_q)));         // R9
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && range_sel == rng_q && fsel == sel_q) |=> (idx_q == $past(idx_q) + 2'd1)); // R9

endmodule

// File: rtl/pair_wave.sv
module pair_wave
  import skew_pkg::*;
#(
  parameter bit WIDE    = 1'b0,
  parameter bit HH_DIV4 = 1'b0,
  parameter int CW      = 6,
  parameter int EW      = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] phase,
  input  logic [1:0]    idx,
  input  logic [CW-1:0] n_cur,
  input  logic [3:0]    sel,
  input  logic          bypass,
  input  logic          byp_ref,
  input  logic [1:0]    byp_div,
  output logic [1:0]    q
);

  pair_cfg_t cfg;

  pair_decode #(.WIDE(WIDE), .HH_DIV4(HH_DIV4)) u_dec (
    .sel (sel),
    .cfg (cfg)
  );

  logic [EW-1:0]   n_e, ph_e, half_e, n2, n4, acc2, acc4;
  logic signed [EW:0] t_s;
  logic            shift_hi, div2_hi, div4_hi, norm_hi, byp_hi, wave_d;

  always_comb begin
    n_e    = EW'(n_cur);
    ph_e   = EW'(phase);
    half_e = n_e >> 1;
    n2     = n_e << 1;
    n4     = n_e << 2;

    t_s = $signed({1'b0, ph_e}) - $signed({{(EW-3){cfg.off[3]}}, cfg.off});
    if (t_s[EW]) t_s = t_s + $signed({1'b0, n_e});
    else if (t_s >= $signed({1'b0, n_e})) t_s = t_s - $signed({1'b0, n_e});
    shift_hi = t_s < $signed({1'b0, half_e});

    acc2 = (idx[0] ? n_e : '0) + ph_e + half_e;
    if (acc2 >= n2) acc2 = acc2 - n2;
    div2_hi = acc2 < n_e;

    acc4 = n_e * EW'(idx) + ph_e + half_e + (half_e << 1);
    if (acc4 >= n4) acc4 = acc4 - n4;
    div4_hi = acc4 < n2;

    case (cfg.fn)
      FN_DIV2: begin norm_hi = div2_hi;      byp_hi = byp_div[0]; end
      FN_DIV4: begin norm_hi = div4_hi;      byp_hi = byp_div[1]; end
      FN_INV:  begin norm_hi = ~(ph_e < half_e); byp_hi = ~byp_ref; end
      default: begin norm_hi = shift_hi;     byp_hi = byp_ref;    end
    endcase
    wave_d = bypass ? byp_hi : norm_hi;
  end

  logic [1:0] q_r;

  for (genvar k = 0; k < 2; k++) begin : g_drv
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r[k] <= 1'b0;
      else        q_r[k] <= wave_d;
    end
  end

  assign q = q_r;

  AST_PAIR_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    q_r[0] == q_r[1]);                                                   // R7

endmodule

// File: rtl/skew_clock_gen.sv
module skew_clock_gen
  import skew_pkg::*;
#(
  parameter int N_LO = 44,
  parameter int N_MD = 26,
  parameter int N_HI = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_in,
  input  logic [1:0]  test_sel,
  input  logic [1:0]  range_sel,
  input  logic [15:0] fsel,
  output logic [3:0]  clk_a,
  output logic [3:0]  clk_b
);

  localparam int NPAIR = 4;
  localparam int SELW  = 4 * NPAIR;
  localparam int NMAX  = (N_LO > N_MD) ? ((N_LO > N_HI) ? N_LO : N_HI)
                                       : ((N_MD > N_HI) ? N_MD : N_HI);
  localparam int CW    = $clog2(NMAX);
  localparam int EW    = $clog2(4 * NMAX) + 1;

  // Reset: asserts at once, releases after two clock edges.
  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  // Reference synchroniser and falling-edge counter for bypass.
  logic [2:0] ref_pipe_q, ref_pipe_d;
  logic [1:0] fcnt_q, fcnt_d;
  logic       ref_fall, bypass;

  always_comb begin
    ref_pipe_d = {ref_pipe_q[1:0], ref_in};
    ref_fall   = ref_pipe_q[2] & ~ref_pipe_q[1];
    fcnt_d     = fcnt_q + {1'b0, ref_fall};
    bypass     = (tern_norm(test_sel) != T_LOW);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ref_pipe_q <= '0;
      fcnt_q     <= '0;
    end else begin
      ref_pipe_q <= ref_pipe_d;
      fcnt_q     <= fcnt_d;
    end
  end

  logic [CW-1:0]   phase, n_cur;
  logic [1:0]      idx;
  logic [SELW-1:0] sel_cur;

  phase_counter #(
    .N_LO(N_LO), .N_MD(N_MD), .N_HI(N_HI), .CW(CW), .SELW(SELW)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .range_sel (range_sel),
    .fsel      (fsel),
    .phase     (phase),
    .idx       (idx),
    .n_cur     (n_cur),
    .sel_cur   (sel_cur)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic [1:0] q_pair;
    pair_wave #(
      .WIDE(p >= 2), .HH_DIV4(p == 2), .CW(CW), .EW(EW)
    ) u_wave (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .phase   (phase),
      .idx     (idx),
      .n_cur   (n_cur),
      .sel     (sel_cur[4*p +: 4]),
      .bypass  (bypass),
      .byp_ref (ref_pipe_q[1]),
      .byp_div (fcnt_d),
      .q       (q_pair)
    );
    assign clk_a[p] = q_pair[0];
    assign clk_b[p] = q_pair[1];
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RST_QUIET: assert (clk_a == '0 && clk_b == '0);                // R10
    end
  end

endmodule

// File: tb/skew_clock_gen_bench.sv
module skew_clock_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 44, NM = 26, NH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        ref_in = 1'b0;
  logic [1:0]  test_sel = 2'b00;
  logic [1:0]  range_sel = 2'b00;
  logic [15:0] fsel = 16'h5555;
  logic [3:0]  clk_a, clk_b;

  skew_clock_gen u_skew_clock_gen (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .test_sel(test_sel),
    .range_sel(range_sel), .fsel(fsel), .clk_a(clk_a), .clk_b(clk_b)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Select codes {F1,F0}
  localparam logic [3:0] LL = 4'b0000, LM = 4'b0001, LH = 4'b0010, ML = 4'b0100,
                         MM = 4'b0101, MH = 4'b0110, HL = 4'b1000, HM = 4'b1001,
                         HH = 4'b1010, XX = 4'b1111;

  int    n_cmp = 0, n_bad = 0;
  bit    done = 1'b0;
  string stim_tag = "R10";

  logic [3:0]  exp_q[$];
  logic [11:0] mode_q[$];
  string       tag_q[$];

  // Reference model state
  int          m_phase, m_idx, rel, fc;
  bit          m_fresh, hs1, hs2, hs3;
  logic [1:0]  m_rng;
  logic [15:0] m_sel;

  function automatic int tnorm(logic [1:0] c);
    return (c == 2'b11) ? 1 : int'(c);
  endfunction

  function automatic int nsel(logic [1:0] r);
    case (tnorm(r))
      0: return NL;
      1: return NM;
      default: return NH;
    endcase
  endfunction

  function automatic string mtag(logic [2:0] m);
    case (m)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R8";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [15:0] pk(logic [3:0] a, logic [3:0] b, logic [3:0] c, logic [3:0] d);
    return {d, c, b, a};
  endfunction

  task automatic push_expect(logic [3:0] e, logic [11:0] md);
    exp_q.push_back(e);
    mode_q.push_back(md);
    tag_q.push_back(stim_tag);
  endtask

  // Predictor: forms the expected output of this edge from the model state
  always @(posedge clk) begin
    logic [3:0]  e;
    logic [11:0] md;
    logic [1:0]  r_use;
    logic [15:0] s_use;
    int          nn, fcn, code, off, kind, f1, f0;
    bit          byp, fall, wrap, chg, b;
    e = '0; md = '0;
    if (!rst_n) begin
      m_phase = 0; m_idx = 0; m_fresh = 1'b1; rel = 0; fc = 0;
      hs1 = 1'b0; hs2 = 1'b0; hs3 = 1'b0; m_rng = '0; m_sel = '0;
    end else if (rel < 2) begin
      rel++;
    end else begin
      byp   = (tnorm(test_sel) != 0);
      fall  = hs3 && !hs2;
      fcn   = (fc + int'(fall)) % 4;
      r_use = m_fresh ? range_sel : m_rng;
      s_use = m_fresh ? fsel : m_sel;
      nn    = nsel(r_use);
      for (int p = 0; p < 4; p++) begin
        f1 = tnorm(s_use[4*p+2 +: 2]);
        f0 = tnorm(s_use[4*p +: 2]);
        code = 3*f1 + f0;
        off = 0;
        if (p < 2) begin kind = 0; off = code - 4; end
        else if (code == 0) kind = 1;
        else if (code == 8) kind = (p == 2) ? 2 : 3;
        else begin kind = 0; off = 2*(code - 4); end
        if (byp) begin
          case (kind)
            0: b = hs2;
            3: b = !hs2;
            1: b = fcn[0];
            default: b = fcn[1];
          endcase
          md[3*p +: 3] = 3'd5;
        end else begin
          case (kind)
            0: b = (((m_phase - off) % nn + nn) % nn) < nn/2;
            3: b = !(m_phase < nn/2);
            1: b = ((((m_idx % 2) * nn + m_phase) + nn/2) % (2*nn)) < nn;
            default: b = ((m_idx * nn + m_phase + 3*nn/2) % (4*nn)) < 2*nn;
          endcase
          md[3*p +: 3] = (kind == 0) ? ((p < 2) ? 3'd1 : 3'd2) : (kind == 3) ? 3'd4 : 3'd3;
        end
        e[p] = b;
      end
      wrap = (m_phase == nn - 1);
      chg  = (range_sel != m_rng) || (fsel != m_sel);
      if (m_fresh || wrap) begin m_rng = range_sel; m_sel = fsel; end
      if (wrap) m_idx = chg ? 0 : (m_idx + 1) % 4;
      m_phase = wrap ? 0 : m_phase + 1;
      m_fresh = 1'b0;
      fc = fcn;
      hs3 = hs2; hs2 = hs1; hs1 = ref_in;
    end
    push_expect(e, md);
  end

  task automatic chk(logic act, logic expv, string req, int p);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s pair%0d actual=%b expected=%b at %0t", req, p + 1, act, expv, $time);
    end
  endtask

  // Monitor: pops one expected item per cycle and compares
  always @(negedge clk) begin
    logic [3:0]  e;
    logic [11:0] md;
    string       t;
    if (exp_q.size() > 0) begin
      e  = exp_q.pop_front();
      md = mode_q.pop_front();
      t  = tag_q.pop_front();
      for (int p = 0; p < 4; p++) begin
        chk(clk_a[p], e[p], {t, "/", mtag(md[3*p +: 3])}, p);
        chk(clk_b[p], e[p], {t, "/", mtag(md[3*p +: 3])}, p);
        chk(clk_b[p], clk_a[p], {t, "/R7"}, p);
      end
    end
  end

  task automatic drive(string tg, logic [1:0] ts, logic [1:0] rg, logic [15:0] fs);
    @(negedge clk); #1;
    stim_tag = tg; test_sel = ts; range_sel = rg; fsel = fs;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle_ref(int gap, int count);
    repeat (count) begin
      repeat (gap) @(negedge clk);
      #1 ref_in = ~ref_in;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R10 actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    run(5);
    #1 rst_n = 1'b1;                                    // R10 reset and start-up
    run(100);
    drive("R3", 2'b00, 2'b00, pk(LL, HH, LM, HM));      // R3 / R4 extreme offsets
    run(150);
    drive("R2", 2'b00, 2'b01, pk(MH, LM, HL, ML));      // R2 mid range
    run(150);
    drive("R5", 2'b00, 2'b10, pk(MM, XX, LL, HH));      // R5 div2, R6 invert, R1 code 11
    run(200);
    drive("R1", 2'b00, 2'b11, pk(MM, MM, HH, LL));      // R1 range 11, R5 div4 and div2
    run(300);
    run(7);
    drive("R9", 2'b00, 2'b00, pk(HL, MM, HH, LL));      // R9 change mid-period
    run(200);
    drive("R8", 2'b10, 2'b10, pk(MH, MM, HH, LL));      // R8 bypass
    toggle_ref(3, 20);
    drive("R8", 2'b11, 2'b10, pk(MH, MM, HH, HH));      // R8 bypass via code 11, invert
    toggle_ref(4, 20);
    toggle_ref(1, 12);
    drive("R10", 2'b00, 2'b10, pk(MM, LH, LM, MM));
    run(23);
    @(negedge clk); #1 rst_n = 1'b0;                    // R10 reset mid-run
    run(3);
    #1 rst_n = 1'b1;
    run(60);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule